// File: doc/BRIEF.md
# Multi-Channel DAC Sweep Waveform Player

This block plays stored voltage-sweep waveforms into a bank of control DACs at a steady sample rate. A programmable divider sets the step period in clock cycles. On every step the block reads one code for each DAC from a byte-wide waveform memory, always in the same order: DAC 0 first and the last DAC at the end, with the high byte of each code before its low byte. It writes each assembled code to that DAC's input register through a simple parallel write port. It then issues a single load strobe, and all DAC outputs change together. Every DAC is rewritten on every step, whether or not its code has changed.

The memory holds two complete table sets. The host selects which set plays next. The new choice is applied only when the sweep wraps from its last sample back to sample 0, so the host can refill the idle set while the other one plays. Memory access is shared with other agents. Each byte read is a valid/ready transfer: the block raises `mem_req` with a stable address, and the read completes in the cycle the arbiter returns `mem_gnt`. The byte is taken from `mem_rdata` in that same cycle. While `mem_gnt` is low the block waits, and address and request stay unchanged. If a step's reads are not finished when the next step is due, that step is dropped and a sticky overrun flag is set.

Top module: `hv_sweep_player`

## Requirements
- R1: While `run` is high, a step is due once every `period` clock cycles. With `mem_gnt` held high and `period` at least 10, consecutive `dac_load` pulses are exactly `period` cycles apart.
- R2: The memory address is {table set (1 bit, MSB), DAC number (2 bits), sample number (11 bits), byte select (1 bit, LSB)}. Byte select 0 is the high byte of the code. Within a step, reads go to DAC 0, 1, 2 and 3 in order, and each DAC's high byte is read before its low byte.
- R3: A read completes only in a cycle where `mem_req` and `mem_gnt` are both high, and the byte is taken from `mem_rdata` in that cycle. While the request waits without a grant, `mem_addr` stays stable.
- R4: On each step, every DAC receives exactly one `dac_wr` pulse. `dac_idx` names the DAC, and `dac_code` equals {high byte, low byte} as read from the memory.
- R5: After the last DAC write of a step, a single `dac_load` pulse follows. It never coincides with `dac_wr`.
- R6: The sample number goes 0, 1, …, NSAMP-1 and then returns to 0, advancing by one per completed step.
- R7: A change on `buf_cmd` takes effect only at the step that follows the wrap from sample NSAMP-1 to 0, or when `run` rises. Steps before that wrap still read the old table set.
- R8: If a step becomes due before the previous step's load has been issued, `overrun` goes high and stays high until reset, and that step is skipped. When no step is late, `overrun` stays low.
- R9: A rising `run` starts the sweep at sample 0 with DAC 0. While `run` is low, no memory request, DAC write or load strobe is issued, so the DAC outputs keep the last loaded codes.
- R10: After reset, `mem_req`, `dac_wr`, `dac_load` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Sweep enable |
| period | input | DIV_W (16) | Step period in clock cycles |
| buf_cmd | input | 1 | Table set requested for the next sweep |
| mem_req | output | 1 | Memory read request (valid) |
| mem_addr | output | 15 | Memory byte address |
| mem_gnt | input | 1 | Memory grant (ready), completes the read |
| mem_rdata | input | 8 | Read byte, valid in the grant cycle |
| dac_wr | output | 1 | DAC input-register write strobe |
| dac_idx | output | 2 | DAC being written |
| dac_code | output | CODE_W (16) | Code written to the DAC |
| dac_load | output | 1 | Common load strobe for all DACs |
| overrun | output | 1 | Sticky late-step flag |

## Verification
Several properties are checked on every cycle by the assertions. The address stays stable while a request waits for its grant. A write only follows a granted read. The load strobe follows the write to the last DAC and never coincides with a write. The sample number stays in range, and the overrun flag never falls. Nothing is issued once `run` drops. Only the bench's scenarios show the actual code values, the ordering of the address fields, the exact step spacing, the postponement of a table switch to the wrap, a rewrite of the idle set during play, and the restart at sample 0. The bench compares the memory data and the run history against a model.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_LOAD  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (period == '0) ? '0 : period - 1'b1;
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == '0)  cnt <= reload;
    else                 cnt <= cnt - 1'b1;
  end

  // R1: a step never repeats in the next cycle unless the period is one
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > 1 && $stable(period)) |=> !tick);
endmodule

// File: rtl/sweep_index.sv
module sweep_index #(
  parameter int NSAMP   = 1344,
  parameter int SAMP_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               advance,
  input  logic               buf_cmd,
  output logic [SAMP_AW-1:0] samp,
  output logic               buf_act
);
  localparam logic [SAMP_AW-1:0] LAST = SAMP_AW'(NSAMP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp    <= '0;
      buf_act <= 1'b0;
    end else if (!run) begin
      samp    <= '0;
      buf_act <= buf_cmd;
    end else if (advance) begin
      if (samp == LAST) begin
        samp    <= '0;
        buf_act <= buf_cmd;
      end else begin
        samp <= samp + 1'b1;
      end
    end
  end

  // R6: sample number never leaves the table
  p_samp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    samp <= LAST);
  // R7: the playing set only changes on a wrap or while stopped
  p_set_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (!advance || samp != LAST)) |=> $stable(buf_act));
endmodule

// File: rtl/fetch_engine.sv
module fetch_engine
  import sweep_pkg::*;
#(
  parameter int NUM_DAC = 4,
  parameter int CODE_W  = 16,
  parameter int SAMP_AW = 11,
  parameter int DAC_W   = $clog2(NUM_DAC),
  parameter int BSEL_W  = $clog2(CODE_W / 8),
  parameter int AW      = 1 + DAC_W + SAMP_AW + BSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [SAMP_AW-1:0] samp,
  input  logic               buf_act,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_gnt,
  input  logic [7:0]         mem_rdata,
  output logic               dac_wr,
  output logic [DAC_W-1:0]   dac_idx,
  output logic [CODE_W-1:0]  dac_code,
  output logic               dac_load,
  output logic               advance,
  output logic               overrun
);
  localparam int HOLD_W = CODE_W - 8;
  localparam logic [DAC_W-1:0]  LAST_D = DAC_W'(NUM_DAC - 1);
  localparam logic [BSEL_W-1:0] LAST_B = BSEL_W'(CODE_W / 8 - 1);

  seq_state_t         state;
  logic [DAC_W-1:0]   dac_cnt;
  logic [BSEL_W-1:0]  byte_cnt;
  logic [HOLD_W-1:0]  hold;

  assign mem_req  = (state == SEQ_FETCH);
  assign mem_addr = {buf_act, dac_cnt, samp, byte_cnt};
  assign advance  = (state == SEQ_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      dac_cnt  <= '0;
      byte_cnt <= '0;
      hold     <= '0;
      dac_wr   <= 1'b0;
      dac_idx  <= '0;
      dac_code <= '0;
      dac_load <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      dac_wr   <= 1'b0;
      dac_load <= 1'b0;
      if (!run) begin
        state    <= SEQ_IDLE;
        dac_cnt  <= '0;
        byte_cnt <= '0;
      end else begin
        if (tick && state != SEQ_IDLE) overrun <= 1'b1;
        unique case (state)
          SEQ_IDLE: if (tick) begin
            state    <= SEQ_FETCH;
            dac_cnt  <= '0;
            byte_cnt <= '0;
          end
          SEQ_FETCH: if (mem_gnt) begin
            if (byte_cnt == LAST_B) begin
              dac_wr   <= 1'b1;
              dac_idx  <= dac_cnt;
              dac_code <= {hold, mem_rdata};
              byte_cnt <= '0;
              if (dac_cnt == LAST_D) state   <= SEQ_LOAD;
              else                   dac_cnt <= dac_cnt + 1'b1;
            end else begin
              hold     <= HOLD_W'({hold, mem_rdata});
              byte_cnt <= byte_cnt + 1'b1;
            end
          end
          SEQ_LOAD: begin
            dac_load <= 1'b1;
            state    <= SEQ_IDLE;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  // R3: a waiting request keeps its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && run) |=> (!mem_req || $stable(mem_addr)));
  // R3: a DAC write only follows a granted read
  p_wr_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> $past(mem_req && mem_gnt));
  // R5: load strobe stands alone
  p_load_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> !dac_wr);
  // R5: load follows the write of the last DAC
  p_load_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> ($past(dac_wr) && $past(dac_idx) == LAST_D));
  // R8: overrun is sticky
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R9: nothing is issued once run is low
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!mem_req && !dac_wr && !dac_load));
endmodule

// File: rtl/hv_sweep_player.sv
module hv_sweep_player #(
  parameter int NUM_DAC = 4,
  parameter int NSAMP   = 1344,
  parameter int SAMP_AW = 11,
  parameter int CODE_W  = 16,
  parameter int DIV_W   = 16
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  run,
  input  logic [DIV_W-1:0]                                      period,
  input  logic                                                  buf_cmd,
  output logic                                                  mem_req,
  output logic [1+$clog2(NUM_DAC)+SAMP_AW+$clog2(CODE_W/8)-1:0] mem_addr,
  input  logic                                                  mem_gnt,
  input  logic [7:0]                                            mem_rdata,
  output logic                                                  dac_wr,
  output logic [$clog2(NUM_DAC)-1:0]                            dac_idx,
  output logic [CODE_W-1:0]                                     dac_code,
  output logic                                                  dac_load,
  output logic                                                  overrun
);
  localparam int DAC_W  = $clog2(NUM_DAC);
  localparam int BSEL_W = $clog2(CODE_W / 8);
  localparam int AW     = 1 + DAC_W + SAMP_AW + BSEL_W;

  logic               tick;
  logic               advance;
  logic               buf_act;
  logic [SAMP_AW-1:0] samp;

  step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .period (period),
    .tick   (tick)
  );

  sweep_index #(.NSAMP(NSAMP), .SAMP_AW(SAMP_AW)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .advance (advance),
    .buf_cmd (buf_cmd),
    .samp    (samp),
    .buf_act (buf_act)
  );

  fetch_engine #(
    .NUM_DAC (NUM_DAC),
    .CODE_W  (CODE_W),
    .SAMP_AW (SAMP_AW),
    .DAC_W   (DAC_W),
    .BSEL_W  (BSEL_W),
    .AW      (AW)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .samp      (samp),
    .buf_act   (buf_act),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .dac_wr    (dac_wr),
    .dac_idx   (dac_idx),
    .dac_code  (dac_code),
    .dac_load  (dac_load),
    .advance   (advance),
    .overrun   (overrun)
  );
endmodule

// File: tb/sim_hv_sweep_player.sv
module sim_hv_sweep_player;
  localparam int NSAMP = 12;
  localparam int NDAC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] period = 16'd12;
  logic        buf_cmd = 1'b0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_gnt = 1'b1;
  logic [7:0]  mem_rdata;
  logic        dac_wr;
  logic [1:0]  dac_idx;
  logic [15:0] dac_code;
  logic        dac_load;
  logic        overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit gnt_all = 1;
  bit chk_int = 0;
  logic [7:0] gen0 = 8'h11;
  logic [7:0] gen1 = 8'hA5;

  int  cyc = 0;
  int  loads = 0, writes = 0, wraps = 0;
  int  last_load = -1;
  int  exp_samp = 0, exp_dac = 0, g_dac = 0, g_byte = 0;
  bit  exp_buf = 0;
  bit  first_req = 0;
  bit  prev_wait = 0;
  logic [14:0] prev_addr = '0;
  logic [15:0] pend [NDAC];
  logic [15:0] dac_out [NDAC];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hv_sweep_player #(.NSAMP(NSAMP)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period), .buf_cmd(buf_cmd),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .dac_wr(dac_wr), .dac_idx(dac_idx),
    .dac_code(dac_code), .dac_load(dac_load), .overrun(overrun)
  );

  function automatic logic [7:0] mbyte(input logic [14:0] a, input logic [7:0] g);
    logic [15:0] m;
    m = a * 16'd13 + {a[14:8], 1'b0} * 16'd7;
    return m[7:0] ^ m[15:8] ^ g;
  endfunction

  function automatic logic [14:0] addr_of(input bit b, input int d, input int s, input bit by);
    return {b, 2'(d), 11'(s), by};
  endfunction

  function automatic logic [15:0] code_of(input bit b, input int d, input int s);
    logic [7:0] g;
    g = b ? gen1 : gen0;
    return {mbyte(addr_of(b, d, s, 1'b0), g), mbyte(addr_of(b, d, s, 1'b1), g)};
  endfunction

  assign mem_rdata = mbyte(mem_addr, mem_addr[14] ? gen1 : gen0);

  always @(posedge clk) begin
    #1;
    mem_gnt <= gnt_all ? 1'b1 : ($urandom % 4 != 0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_wr) begin
        chk(dac_idx == 2'(exp_dac), "R4 dac order", 32'(dac_idx), 32'(exp_dac));
        chk(dac_code == code_of(exp_buf, exp_dac, exp_samp), "R4 code value",
            32'(dac_code), 32'(code_of(exp_buf, exp_dac, exp_samp)));
        pend[dac_idx] = dac_code;
        exp_dac++;
        writes++;
      end
      if (dac_load) begin
        chk(exp_dac == NDAC, "R5 load after all writes", 32'(exp_dac), 32'(NDAC));
        for (int i = 0; i < NDAC; i++) dac_out[i] = pend[i];
        if (chk_int && last_load >= 0)
          chk(cyc - last_load == int'(period), "R1 step spacing", 32'(cyc - last_load), 32'(period));
        last_load = cyc;
        loads++;
        exp_dac = 0;
        g_dac = 0;
        if (exp_samp == NSAMP - 1) begin
          exp_samp = 0;
          exp_buf = buf_cmd;
          wraps++;
        end else begin
          exp_samp++;
        end
      end
      if (run && mem_req) begin
        if (first_req) begin
          chk(mem_addr[11:1] == 11'd0 && mem_addr[13:12] == 2'd0 && mem_addr[0] == 1'b0,
              "R9 restart at sample 0", 32'(mem_addr), 32'(addr_of(exp_buf, 0, 0, 1'b0)));
          first_req = 0;
        end
        if (prev_wait)
          chk(mem_addr == prev_addr, "R3 address held", 32'(mem_addr), 32'(prev_addr));
        if (mem_gnt) begin
          chk(mem_addr == addr_of(exp_buf, g_dac, exp_samp, 1'(g_byte)), "R2 address order",
              32'(mem_addr), 32'(addr_of(exp_buf, g_dac, exp_samp, 1'(g_byte))));
          if (g_byte == 1) begin g_byte = 0; g_dac++; end
          else g_byte = 1;
        end
      end
      prev_wait = run && mem_req && !mem_gnt;
      prev_addr = mem_addr;
    end
  end

  task automatic start_run();
    exp_samp = 0; exp_dac = 0; g_dac = 0; g_byte = 0;
    exp_buf = buf_cmd; last_load = -1; first_req = 1; prev_wait = 0;
    run = 1'b1;
  endtask

  task automatic stop_run();
    run = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wait_loads(input int n);
    int target;
    target = loads + n;
    while (loads < target) @(posedge clk);
    #1;
  endtask

  initial begin
    int snap_l, snap_w;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R10: reset state
    chk(!mem_req && !dac_wr && !dac_load, "R10 idle outputs in reset",
        {29'd0, mem_req, dac_wr, dac_load}, 32'd0);
    chk(!overrun, "R10 overrun clear", 32'(overrun), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Directed: full grant, spacing, wrap and table switch
    gnt_all = 1; chk_int = 1; period = 16'd12;
    start_run();
    wait_loads(5);
    buf_cmd = 1'b1;                       // R7: requested mid-sweep
    while (wraps < 1) @(posedge clk);
    #1;
    chk(exp_buf == 1'b1, "R7 switch applied at wrap", 32'(exp_buf), 32'd1);
    gen0 = 8'h3C;                         // refill idle set while set 1 plays
    wait_loads(2 * NSAMP);
    chk(wraps >= 3, "R6 sample wrap count", 32'(wraps), 32'd3);
    chk(!overrun, "R8 no overrun at safe period", 32'(overrun), 32'd0);

    // Random grants with random table switches
    stop_run();
    gnt_all = 0; chk_int = 0; period = 16'd60;
    start_run();
    for (int k = 0; k < 8; k++) begin
      wait_loads(1 + ($urandom % 5));
      if (exp_samp > 1 && exp_samp < NSAMP - 2) begin
        if (exp_buf) gen0 = 8'($urandom); else gen1 = 8'($urandom);
        buf_cmd = 1'($urandom);
      end
    end
    wait_loads(NSAMP);
    chk(!overrun, "R8 no overrun with slow grants", 32'(overrun), 32'd0);

    // Stop in the middle of a step
    while (!mem_req) @(posedge clk);
    #1;
    stop_run();
    snap_l = loads; snap_w = writes;
    repeat (100) @(posedge clk);
    #1;
    chk(loads == snap_l, "R9 no load while stopped", 32'(loads), 32'(snap_l));
    chk(writes == snap_w, "R9 no write while stopped", 32'(writes), 32'(snap_w));
    chk(!mem_req, "R9 no request while stopped", 32'(mem_req), 32'd0);

    // Restart, then provoke overrun
    gnt_all = 1; chk_int = 1; period = 16'd12;
    start_run();
    wait_loads(4);
    stop_run();
    chk_int = 0; period = 16'd6;
    start_run();
    wait_loads(6);
    chk(overrun, "R8 overrun on late step", 32'(overrun), 32'd1);
    stop_run();
    period = 16'd20;
    start_run();
    wait_loads(4);
    chk(overrun, "R8 overrun sticky", 32'(overrun), 32'd1);

    // Reset mid-run
    rst_n = 1'b0; run = 1'b0;
    @(negedge clk);
    chk(!overrun && !mem_req && !dac_wr && !dac_load, "R10 reset clears",
        {28'd0, overrun, mem_req, dac_wr, dac_load}, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule